// File: doc/BRIEF.md
# Calendar Slot Spacing Checker

The block holds a circular slot calendar of up to 64 entries plus one expected average distance for each of 13 devices. After a start pulse it walks the calendar once per device and judges whether the slots owned by that device are spread evenly enough around the ring. It reports the first device whose spacing is too uneven, together with the deviation that broke the limit.

Software or a calendar builder loads the entries through a simple write port. Each entry holds a device number. The value 0xFFFF marks an unused entry. The average distances are loaded through a second write port, in tenths of a slot. The check then runs on its own and ends with `done` high and a pass or fail verdict. The verdict stays in place until the next start is accepted.

For one device, the gaps between its owned slots are taken in order around the ring. The walk closes through the wrap from the last owned slot back to the first. Starting from each gap in turn, a running deviation is carried around the whole ring. The check fails if, at any added gap, that running deviation exceeds the expected average.

Top module: `cal_spacing_chk`

## Requirements
- R1: The calendar length is the number of entries among all 64 that differ from 0xFFFF. Only indices 0 up to that length minus one are searched for owned slots. A non-empty entry at a higher index is ignored.
- R2: A device's owned indices are listed in ascending order, and the first index plus the calendar length is appended to close the ring. Each gap is the difference of consecutive listed indices times 10, so gaps are in tenths of a slot.
- R3: For each starting gap, the running value is first set to |gap − average|. This first value is never compared against the limit. As a result, a device owning exactly one slot always passes.
- R4: From the start gap, the running value visits every other gap once, in ring order. At each gap it becomes |running + gap − average|. The check fails as soon as this value is strictly greater than the average.
- R5: Devices are checked in ascending order from 0 to 12. On the first failure the check stops, `pass` is 0, `fail_dev` holds that device and `fail_val` holds the offending running value.
- R6: A device whose average register is 0xFFFF is skipped and can never fail.
- R7: A device owning no slot within the calendar length passes. If no device fails, `done` rises with `pass` at 1 and `fail_dev` and `fail_val` at 0.
- R8: After reset, `done` and `pass` are 0, every calendar entry is 0xFFFF and every average is 0xFFFF. A check started from that state passes.
- R9: A start is accepted only while no check is running, and accepting it clears `done`, `pass`, `fail_dev` and `fail_val`. A start during a run is ignored. The verdict holds until the next accepted start.
- R10: `cal_we` writes `cal_wdata` into entry `cal_addr`. `avg_we` writes `avg_wdata` into the average of device `avg_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_we | input | 1 | Calendar entry write strobe |
| cal_addr | input | 6 | Calendar entry index |
| cal_wdata | input | 16 | Device number, 0xFFFF for unused |
| avg_we | input | 1 | Average distance write strobe |
| avg_sel | input | 4 | Device whose average is written |
| avg_wdata | input | 16 | Expected average distance in tenths of a slot, 0xFFFF disables |
| start | input | 1 | Start pulse |
| done | output | 1 | Check finished, held until next accepted start |
| pass | output | 1 | All devices within limits |
| fail_dev | output | 4 | First failing device |
| fail_val | output | 20 | Running deviation that exceeded the average |

## Verification
The bench targets the ring-closing gap. A checker that appended the plain length instead of first index plus length would flag a device whose slots start past index 0. It also targets a hole of 0xFFFF inside the calendar: a design that scanned all 64 entries instead of the counted length would see an extra owned slot and fail a device that should pass. A single-slot device with a tiny average only passes if the first running value is never compared. Two failing devices must report the lower one, a disabled device must not be reported, and a start pulse mid-run must not restart or corrupt the walk. Pseudo-random calendars are compared against a behavioural model written from the requirements.

// File: rtl/cal_spacing_chk.sv
module cal_spacing_chk #(
  parameter int DEPTH = 64,
  parameter int NDEV  = 13,
  parameter int EW    = 16,
  parameter int AW    = 16,
  parameter int CW    = AW + 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cal_we,
  input  logic [$clog2(DEPTH)-1:0]  cal_addr,
  input  logic [EW-1:0]             cal_wdata,
  input  logic                      avg_we,
  input  logic [$clog2(NDEV)-1:0]   avg_sel,
  input  logic [AW-1:0]             avg_wdata,
  input  logic                      start,
  output logic                      done,
  output logic                      pass,
  output logic [$clog2(NDEV)-1:0]   fail_dev,
  output logic [CW-1:0]             fail_val
);
  localparam int IW  = $clog2(DEPTH);
  localparam int PW  = IW + 1;
  localparam int DVW = $clog2(NDEV);
  localparam logic [PW-1:0]  ONE  = PW'(1);
  localparam logic [DVW-1:0] LAST = DVW'(NDEV - 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_SCAN, S_INIT, S_STEP} st_t;

  st_t                    state;
  logic [EW-1:0]          cal [DEPTH];
  logic [AW-1:0]          avg [NDEV];
  logic [PW-1:0]          pos [DEPTH+1];
  logic [PW-1:0]          len_c, len_q, scan_i, n_q, s_q, j_q, k_q;
  logic [DVW-1:0]         dev_q;
  logic signed [CW-1:0]   run_q;
  logic                   done_q, pass_q;
  logic [DVW-1:0]         fail_dev_q;
  logic [CW-1:0]          fail_val_q;

  function automatic logic signed [CW-1:0] absf(input logic signed [CW-1:0] x);
    return (x < 0) ? -x : x;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cal[i] <= '1;
    end else if (cal_we) begin
      cal[cal_addr] <= cal_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NDEV; i++) avg[i] <= '1;
    end else if (avg_we) begin
      avg[avg_sel] <= avg_wdata;
    end
  end

  always_comb begin
    len_c = '0;
    for (int i = 0; i < DEPTH; i++)
      if (cal[i] != '1) len_c = len_c + ONE;
  end

  logic [AW-1:0]        avg_cur;
  logic signed [CW-1:0] avg_s, gap_s, gap_j, t_init, t_step;
  logic [PW-1:0]        d_s, d_j, s_nx, j_nx;
  logic [CW-1:0]        g_s_u, g_j_u;
  logic                 last_dev, own;

  assign avg_cur  = avg[dev_q];
  assign avg_s    = $signed(CW'(avg_cur));
  assign s_nx     = s_q + ONE;
  assign j_nx     = (j_q + ONE == n_q) ? '0 : j_q + ONE;
  assign d_s      = pos[s_q + ONE] - pos[s_q];
  assign d_j      = pos[j_q + ONE] - pos[j_q];
  assign g_s_u    = CW'(d_s) * CW'(10);
  assign g_j_u    = CW'(d_j) * CW'(10);
  assign gap_s    = $signed(g_s_u);
  assign gap_j    = $signed(g_j_u);
  assign t_init   = absf(gap_s - avg_s);
  assign t_step   = absf(run_q + gap_j - avg_s);
  assign last_dev = (dev_q == LAST);
  assign own      = (cal[scan_i[IW-1:0]] == EW'(dev_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      len_q      <= '0;
      scan_i     <= '0;
      n_q        <= '0;
      s_q        <= '0;
      j_q        <= '0;
      k_q        <= '0;
      dev_q      <= '0;
      run_q      <= '0;
      done_q     <= 1'b0;
      pass_q     <= 1'b0;
      fail_dev_q <= '0;
      fail_val_q <= '0;
      for (int i = 0; i <= DEPTH; i++) pos[i] <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          len_q      <= len_c;
          dev_q      <= '0;
          done_q     <= 1'b0;
          pass_q     <= 1'b0;
          fail_dev_q <= '0;
          fail_val_q <= '0;
          state      <= S_DEV;
        end
        S_DEV: begin
          if (avg_cur == '1) begin
            if (last_dev) begin
              state  <= S_IDLE;
              done_q <= 1'b1;
              pass_q <= 1'b1;
            end else begin
              dev_q <= dev_q + DVW'(1);
            end
          end else begin
            scan_i <= '0;
            n_q    <= '0;
            state  <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (scan_i == len_q) begin
            pos[n_q] <= pos[0] + len_q;
            if (n_q == '0) begin
              if (last_dev) begin
                state  <= S_IDLE;
                done_q <= 1'b1;
                pass_q <= 1'b1;
              end else begin
                dev_q <= dev_q + DVW'(1);
                state <= S_DEV;
              end
            end else begin
              s_q   <= '0;
              state <= S_INIT;
            end
          end else begin
            if (own) begin
              pos[n_q] <= scan_i;
              n_q      <= n_q + ONE;
            end
            scan_i <= scan_i + ONE;
          end
        end
        S_INIT: begin
          run_q <= t_init;
          j_q   <= (s_nx == n_q) ? '0 : s_nx;
          k_q   <= ONE;
          state <= S_STEP;
        end
        S_STEP: begin
          if (k_q == n_q) begin
            if (s_nx == n_q) begin
              if (last_dev) begin
                state  <= S_IDLE;
                done_q <= 1'b1;
                pass_q <= 1'b1;
              end else begin
                dev_q <= dev_q + DVW'(1);
                state <= S_DEV;
              end
            end else begin
              s_q   <= s_nx;
              state <= S_INIT;
            end
          end else if (t_step > avg_s) begin
            state      <= S_IDLE;
            done_q     <= 1'b1;
            pass_q     <= 1'b0;
            fail_dev_q <= dev_q;
            fail_val_q <= $unsigned(t_step);
          end else begin
            run_q <= t_step;
            j_q   <= j_nx;
            k_q   <= k_q + ONE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign done     = done_q;
  assign pass     = pass_q;
  assign fail_dev = fail_dev_q;
  assign fail_val = fail_val_q;

  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state == S_IDLE) |=> (!done && !pass));
  a_r9_verdict_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(pass) && $stable(fail_dev) && $stable(fail_val)));
  a_r4_fail_above_avg: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !pass) |-> (fail_val > CW'(avg[fail_dev])));
  a_r6_disabled_never_fails: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !pass) |-> (avg[fail_dev] != '1));
  a_r5_dev_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pass) |-> (fail_dev <= LAST));
  a_r7_pass_clean: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> (done && fail_dev == '0 && fail_val == '0));
  a_r1_scan_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SCAN) |-> (scan_i <= len_q && len_q <= PW'(DEPTH)));
endmodule

// File: tb/cal_spacing_chk_test.sv
module cal_spacing_chk_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cal_we = 1'b0, avg_we = 1'b0, start = 1'b0;
  logic [5:0]  cal_addr = '0;
  logic [15:0] cal_wdata = '0, avg_wdata = '0;
  logic [3:0]  avg_sel = '0;
  logic done, pass;
  logic [3:0]  fail_dev;
  logic [19:0] fail_val;

  int checks = 0, failures = 0;
  logic [15:0] m_cal [64];
  logic [15:0] m_avg [13];
  logic [31:0] lfsr = 32'h1ACE_5EED;

  always #5 clk = ~clk;

  cal_spacing_chk uut (.clk, .rst_n, .cal_we, .cal_addr, .cal_wdata, .avg_we,
    .avg_sel, .avg_wdata, .start, .done, .pass, .fail_dev, .fail_val);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_cal(input int i, input int v);
    @(negedge clk); cal_we = 1; cal_addr = 6'(i); cal_wdata = 16'(v); m_cal[i] = 16'(v);
    @(negedge clk); cal_we = 0;
  endtask

  task automatic wr_avg(input int d, input int v);
    @(negedge clk); avg_we = 1; avg_sel = 4'(d); avg_wdata = 16'(v); m_avg[d] = 16'(v);
    @(negedge clk); avg_we = 0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 64; i++) if (m_cal[i] != 16'hFFFF) wr_cal(i, 16'hFFFF);
    for (int d = 0; d < 13; d++) if (m_avg[d] != 16'hFFFF) wr_avg(d, 16'hFFFF);
  endtask

  task automatic model(output bit ok, output int dev, output int val);
    int len, n, a, c, g;
    int p [65];
    ok = 1; dev = 0; val = 0; len = 0;
    for (int i = 0; i < 64; i++) if (m_cal[i] != 16'hFFFF) len++;
    for (int d = 0; d < 13; d++) begin
      if (m_avg[d] == 16'hFFFF) continue;
      a = int'(m_avg[d]); n = 0;
      for (int i = 0; i < len; i++) if (m_cal[i] == 16'(d)) begin p[n] = i; n++; end
      if (n == 0) continue;
      p[n] = p[0] + len;
      for (int s = 0; s < n; s++) begin
        c = (p[s+1] - p[s]) * 10 - a; if (c < 0) c = -c;
        for (int k = 1; k < n; k++) begin
          g = (p[(s+k)%n + 1] - p[(s+k)%n]) * 10;
          c = c + g - a; if (c < 0) c = -c;
          if (c > a) begin ok = 0; dev = d; val = c; return; end
        end
      end
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1; @(negedge clk); start = 0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!done && t < 100000) begin @(negedge clk); t++; end
    chk(done, req, int'(done), 1);
  endtask

  task automatic run_cmp(input string req);
    bit ok; int d, v;
    model(ok, d, v);
    pulse_start();
    wait_done(req);
    chk(pass == ok, req, int'(pass), int'(ok));
    if (!ok) begin
      chk(fail_dev == 4'(d), req, int'(fail_dev), d);
      chk(fail_val == 20'(v), req, int'(fail_val), v);
    end
  endtask

  task automatic t_reset();
    chk(!done && !pass, "R8 reset outputs", int'({done, pass}), 0);
    pulse_start(); wait_done("R8 empty start");
    chk(pass && fail_val == 0, "R8 empty passes", int'(pass), 1);
  endtask

  task automatic t_even();
    clear_all();
    wr_cal(0, 13); wr_cal(1, 0); wr_cal(2, 13); wr_cal(3, 0);
    wr_avg(0, 20);
    pulse_start(); wait_done("R2 ring close");
    chk(pass, "R2 ring close pass", int'(pass), 1);
    wr_avg(0, 10);
    pulse_start(); wait_done("R4 even fail");
    chk(!pass && fail_dev == 0, "R4 even fail dev", int'(fail_dev), 0);
    chk(fail_val == 20, "R4 even fail value", int'(fail_val), 20);
    run_cmp("R10 R4 model even");
  endtask

  task automatic t_uneven();
    clear_all();
    wr_cal(0, 1); wr_cal(1, 1); wr_cal(2, 13); wr_cal(3, 13);
    wr_avg(1, 20);
    pulse_start(); wait_done("R4 uneven");
    chk(pass, "R4 uneven within limit", int'(pass), 1);
    wr_avg(1, 15);
    pulse_start(); wait_done("R4 uneven fail");
    chk(!pass && fail_dev == 1, "R4 uneven fail dev", int'(fail_dev), 1);
    chk(fail_val == 20, "R4 uneven fail value", int'(fail_val), 20);
  endtask

  task automatic t_single();
    clear_all();
    wr_cal(0, 3); wr_cal(1, 13); wr_cal(2, 13); wr_cal(3, 13);
    wr_avg(3, 5); wr_avg(4, 1);
    pulse_start(); wait_done("R3 single slot");
    chk(pass, "R3 R7 single and absent devices pass", int'(pass), 1);
  endtask

  task automatic t_hole();
    clear_all();
    wr_cal(0, 0); wr_cal(1, 13); wr_cal(3, 0);
    wr_avg(0, 5);
    pulse_start(); wait_done("R1 hole");
    chk(pass, "R1 entry beyond length ignored", int'(pass), 1);
  endtask

  task automatic t_order();
    clear_all();
    wr_cal(0, 2); wr_cal(1, 5); wr_cal(2, 2); wr_cal(3, 5); wr_cal(4, 13); wr_cal(5, 13);
    wr_avg(2, 10); wr_avg(5, 10);
    pulse_start(); wait_done("R5 order");
    chk(!pass && fail_dev == 2, "R5 lowest device reported", int'(fail_dev), 2);
    wr_avg(2, 16'hFFFF);
    pulse_start(); wait_done("R6 disable");
    chk(!pass && fail_dev == 5, "R6 disabled device skipped", int'(fail_dev), 5);
    wr_avg(5, 16'hFFFF);
    pulse_start(); wait_done("R6 all disabled");
    chk(pass, "R6 disabled devices pass", int'(pass), 1);
  endtask

  task automatic fill_random(input int len);
    clear_all();
    for (int i = 0; i < len; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      wr_cal(i, int'(lfsr[15:0] % 14));
    end
    for (int d = 0; d < 13; d++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      wr_avg(d, 40 + int'(lfsr[7:0]) * 3);
    end
  endtask

  task automatic t_busy();
    bit ok; int d, v;
    fill_random(64);
    for (int d2 = 0; d2 < 13; d2++) wr_avg(d2, 2000);
    model(ok, d, v);
    pulse_start();
    repeat (20) @(negedge clk);
    chk(!done, "R9 done low while running", int'(done), 0);
    pulse_start();
    wait_done("R9 busy");
    chk(pass == ok, "R9 start during run ignored", int'(pass), int'(ok));
    pulse_start();
    chk(!done, "R9 accepted start clears done", int'(done), 0);
    wait_done("R9 rerun");
  endtask

  task automatic t_random();
    for (int r = 0; r < 6; r++) begin
      fill_random(8 + r * 9);
      run_cmp("R4 R5 random");
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) m_cal[i] = 16'hFFFF;
    for (int d = 0; d < 13; d++) m_avg[d] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_even();
    t_uneven();
    t_single();
    t_hole();
    t_order();
    t_busy();
    t_random();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1900000;
    checks++; failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule